// File: doc/BRIEF.md
# Write Buffer Allocator

This block decides which of eight write data buffers receives each new write command entering a memory controller's command queue. It keeps a pending-command count for every buffer and, for every source ID, a record of the buffer that source wrote to most recently. A write from a source whose record is still live goes to that same buffer, so one source's data always drains from one buffer in arrival order. A write from any other source goes to the lowest-numbered empty buffer.

The choice is made combinationally in the cycle the request is presented. The block also returns a link. When the selected buffer still holds data for a queued command, it raises a flag and gives the queue slot of the newest such command. The placement logic must then place the new write behind that slot, whatever its priority.

The queue reports each retired command by buffer index. That lowers the buffer's count. When the count reaches zero the buffer is empty again, and every source record that pointed at it is dropped.

Top module: `wrbuf_alloc`

## Requirements
- R1: After reset every buffer is empty and no source record exists. The first request is therefore ready, is granted buffer 0 and carries no link.
- R2: A request from a source with no live record is granted the lowest-numbered buffer whose pending count is zero.
- R3: A request from a source with a live record is granted the buffer in that record, even when a lower-numbered empty buffer exists.
- R4: When a request is ready and its granted buffer has a non-zero pending count, `link_valid` is 1 and `link_slot` equals the `req_slot` of the most recent accepted write into that buffer. Otherwise `link_valid` is 0.
- R5: Each retire lowers the pending count of `ret_buf` by one. A buffer whose count reaches zero can be chosen as an empty buffer again, and a source that pointed at it is then treated as having no record.
- R6: When the source has no live record and no buffer is empty, `req_ready` is 0 and nothing is accepted. The stall lasts until a retire empties a buffer.
- R7: When the source's recorded buffer already holds QSLOTS pending commands, `req_ready` is 0.
- R8: An accept and a retire on the same buffer in the same cycle leave its count unchanged. A buffer at count 1 is therefore not freed, and the source keeps its record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A write command asks for a buffer |
| req_src | input | $clog2(NUM_SRC) | Source ID of the write |
| req_slot | input | $clog2(QSLOTS) | Queue slot the write will occupy |
| req_ready | output | 1 | A buffer is available; the write is accepted when req_valid is also 1 |
| grant_buf | output | $clog2(NUM_BUF) | Buffer chosen for the write |
| link_valid | output | 1 | The chosen buffer serves a queued command |
| link_slot | output | $clog2(QSLOTS) | Queue slot of the newest command in the chosen buffer |
| ret_valid | input | 1 | A queued write has retired |
| ret_buf | input | $clog2(NUM_BUF) | Buffer of the retired write |

## Verification
The checks assume that the queue never retires a command from a buffer whose pending count is zero. They also assume that `req_src` and `req_slot` are stable within each cycle in which a request is held. The bench keeps within these limits. It tracks the count of each buffer and retires only from buffers its model shows as non-empty. It drives every input once per cycle, half a period away from the active edge.

// File: rtl/wba_pkg.sv
package wba_pkg;

    localparam int unsigned DEF_NUM_BUF = 8;
    localparam int unsigned DEF_NUM_SRC = 16;
    localparam int unsigned DEF_QSLOTS  = 16;

    // how the buffer of the current request was chosen
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_AFFINE = 2'd1,
        SEL_FRESH  = 2'd2
    } sel_e;

    // counter width able to hold 0..depth
    function automatic int unsigned cnt_width(int unsigned depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/wba_lowest_free.sv
module wba_lowest_free #(
    parameter int unsigned NUM_BUF = wba_pkg::DEF_NUM_BUF,
    parameter int unsigned BUF_W   = $clog2(NUM_BUF)
) (
    input  logic [NUM_BUF-1:0] free_vec,
    output logic               found,
    output logic [BUF_W-1:0]   idx
);
    // scan downward so the lowest set bit wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_BUF - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                found = 1'b1;
                idx   = BUF_W'(i);
            end
        end
    end
endmodule

// File: rtl/wba_occupancy.sv
module wba_occupancy #(
    parameter int unsigned NUM_BUF = wba_pkg::DEF_NUM_BUF,
    parameter int unsigned QSLOTS  = wba_pkg::DEF_QSLOTS,
    parameter int unsigned BUF_W   = $clog2(NUM_BUF),
    parameter int unsigned SLOT_W  = $clog2(QSLOTS),
    parameter int unsigned CNT_W   = wba_pkg::cnt_width(QSLOTS)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            acc_valid,
    input  logic [BUF_W-1:0]                acc_buf,
    input  logic [SLOT_W-1:0]               acc_slot,
    input  logic                            ret_valid,
    input  logic [BUF_W-1:0]                ret_buf,
    output logic [NUM_BUF-1:0]              busy,
    output logic [NUM_BUF-1:0]              full,
    output logic [NUM_BUF-1:0]              freed,
    output logic [NUM_BUF-1:0][SLOT_W-1:0]  last_slot
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(QSLOTS);

    for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
        logic [CNT_W-1:0]  cnt_q;
        logic [CNT_W-1:0]  cnt_d;
        logic [SLOT_W-1:0] slot_q;
        logic              inc;
        logic              dec;

        assign inc = acc_valid && (acc_buf == BUF_W'(g));
        assign dec = ret_valid && (ret_buf == BUF_W'(g)) && (cnt_q != '0);

        always_comb begin
            case ({inc, dec})
                2'b10:   cnt_d = cnt_q + 1'b1;
                2'b01:   cnt_d = cnt_q - 1'b1;
                default: cnt_d = cnt_q;
            endcase
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q  <= '0;
                slot_q <= '0;
            end else begin
                cnt_q <= cnt_d;
                if (inc) slot_q <= acc_slot;
            end
        end

        assign busy[g]      = (cnt_q != '0);
        assign full[g]      = (cnt_q == CNT_MAX);
        assign freed[g]     = (cnt_q != '0) && (cnt_d == '0);
        assign last_slot[g] = slot_q;
    end
endmodule

// File: rtl/wba_src_map.sv
module wba_src_map #(
    parameter int unsigned NUM_SRC = wba_pkg::DEF_NUM_SRC,
    parameter int unsigned NUM_BUF = wba_pkg::DEF_NUM_BUF,
    parameter int unsigned SRC_W   = $clog2(NUM_SRC),
    parameter int unsigned BUF_W   = $clog2(NUM_BUF)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               acc_valid,
    input  logic [SRC_W-1:0]   acc_src,
    input  logic [BUF_W-1:0]   acc_buf,
    input  logic [NUM_BUF-1:0] freed,
    input  logic [SRC_W-1:0]   qry_src,
    output logic               hit,
    output logic [BUF_W-1:0]   hit_buf
);
    logic [NUM_SRC-1:0]            vld;
    logic [NUM_SRC-1:0][BUF_W-1:0] bufs;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        logic             valid_q;
        logic [BUF_W-1:0] buf_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q <= 1'b0;
                buf_q   <= '0;
            end else if (acc_valid && (acc_src == SRC_W'(s))) begin
                valid_q <= 1'b1;
                buf_q   <= acc_buf;
            end else if (valid_q && freed[buf_q]) begin
                valid_q <= 1'b0;
            end
        end

        assign vld[s]  = valid_q;
        assign bufs[s] = buf_q;
    end

    assign hit     = vld[qry_src];
    assign hit_buf = bufs[qry_src];
endmodule

// File: rtl/wrbuf_alloc.sv
module wrbuf_alloc #(
    parameter int unsigned NUM_BUF = wba_pkg::DEF_NUM_BUF,
    parameter int unsigned NUM_SRC = wba_pkg::DEF_NUM_SRC,
    parameter int unsigned QSLOTS  = wba_pkg::DEF_QSLOTS
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic [$clog2(NUM_SRC)-1:0] req_src,
    input  logic [$clog2(QSLOTS)-1:0]  req_slot,
    output logic                       req_ready,
    output logic [$clog2(NUM_BUF)-1:0] grant_buf,
    output logic                       link_valid,
    output logic [$clog2(QSLOTS)-1:0]  link_slot,
    input  logic                       ret_valid,
    input  logic [$clog2(NUM_BUF)-1:0] ret_buf
);
    import wba_pkg::*;

    localparam int unsigned BUF_W  = $clog2(NUM_BUF);
    localparam int unsigned SRC_W  = $clog2(NUM_SRC);
    localparam int unsigned SLOT_W = $clog2(QSLOTS);
    localparam int unsigned CNT_W  = cnt_width(QSLOTS);

    logic [NUM_BUF-1:0]             busy;
    logic [NUM_BUF-1:0]             full;
    logic [NUM_BUF-1:0]             freed;
    logic [NUM_BUF-1:0][SLOT_W-1:0] last_slot;
    logic                           hit;
    logic [BUF_W-1:0]               hit_buf;
    logic                           found;
    logic [BUF_W-1:0]               low_idx;
    logic [BUF_W-1:0]               chosen;
    logic                           accept;
    sel_e                           sel;

    wba_occupancy #(
        .NUM_BUF(NUM_BUF), .QSLOTS(QSLOTS),
        .BUF_W(BUF_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)
    ) u_occ (
        .clk(clk), .rst(rst),
        .acc_valid(accept), .acc_buf(chosen), .acc_slot(req_slot),
        .ret_valid(ret_valid), .ret_buf(ret_buf),
        .busy(busy), .full(full), .freed(freed), .last_slot(last_slot)
    );

    wba_src_map #(
        .NUM_SRC(NUM_SRC), .NUM_BUF(NUM_BUF), .SRC_W(SRC_W), .BUF_W(BUF_W)
    ) u_map (
        .clk(clk), .rst(rst),
        .acc_valid(accept), .acc_src(req_src), .acc_buf(chosen),
        .freed(freed), .qry_src(req_src),
        .hit(hit), .hit_buf(hit_buf)
    );

    wba_lowest_free #(
        .NUM_BUF(NUM_BUF), .BUF_W(BUF_W)
    ) u_pick (
        .free_vec(~busy), .found(found), .idx(low_idx)
    );

    always_comb begin
        if (hit) begin
            sel       = SEL_AFFINE;
            chosen    = hit_buf;
            req_ready = !full[hit_buf];
        end else if (found) begin
            sel       = SEL_FRESH;
            chosen    = low_idx;
            req_ready = 1'b1;
        end else begin
            sel       = SEL_NONE;
            chosen    = '0;
            req_ready = 1'b0;
        end
    end

    assign accept     = req_valid && req_ready;
    assign grant_buf  = chosen;
    assign link_valid = (sel != SEL_NONE) && busy[chosen];
    assign link_slot  = last_slot[chosen];
endmodule

// File: rtl/wrbuf_alloc_chk.sv
module wrbuf_alloc_chk #(
    parameter int unsigned NUM_BUF = 8,
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned QSLOTS  = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       req_valid,
    input logic [$clog2(NUM_SRC)-1:0] req_src,
    input logic [$clog2(QSLOTS)-1:0]  req_slot,
    input logic                       req_ready,
    input logic [$clog2(NUM_BUF)-1:0] grant_buf,
    input logic                       link_valid,
    input logic [$clog2(QSLOTS)-1:0]  link_slot,
    input logic                       ret_valid,
    input logic [$clog2(NUM_BUF)-1:0] ret_buf,
    input logic [NUM_BUF-1:0]         busy
);
    // first cycle out of reset: everything empty
    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !link_valid && grant_buf == '0));

    // a source that just wrote is steered back to the same buffer
    assert_affinity_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=>
            (!(req_valid && req_src == $past(req_src)) || grant_buf == $past(grant_buf)));

    // and the link names the slot of that previous write
    assert_link_prev_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=>
            (!(req_valid && req_src == $past(req_src))
             || (link_valid && link_slot == $past(req_slot))));

    // with no retire, a stalled request stays stalled
    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready && !ret_valid) |=>
            (!(req_valid && $stable(req_src)) || !req_ready));

    // input assumption: retires only target occupied buffers
    assert_ret_busy_R5: assert property (@(posedge clk) disable iff (rst)
        ret_valid |-> busy[ret_buf]);
endmodule

bind wrbuf_alloc wrbuf_alloc_chk #(
    .NUM_BUF(NUM_BUF), .NUM_SRC(NUM_SRC), .QSLOTS(QSLOTS)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_src(req_src),
    .req_slot(req_slot), .req_ready(req_ready), .grant_buf(grant_buf),
    .link_valid(link_valid), .link_slot(link_slot), .ret_valid(ret_valid),
    .ret_buf(ret_buf), .busy(busy)
);

// File: tb/tb_wrbuf_alloc.sv
module tb_wrbuf_alloc;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 8;
    localparam int NS = 16;
    localparam int QS = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [3:0] req_src = '0;
    logic [3:0] req_slot = '0;
    logic       req_ready;
    logic [2:0] grant_buf;
    logic       link_valid;
    logic [3:0] link_slot;
    logic       ret_valid = 1'b0;
    logic [2:0] ret_buf = '0;

    int errs = 0;
    int total = 0;
    bit done = 0;

    // reference model
    int m_cnt [NB];
    int m_last[NB];
    bit m_sv  [NS];
    int m_sb  [NS];

    wrbuf_alloc #(.NUM_BUF(NB), .NUM_SRC(NS), .QSLOTS(QS)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_src(req_src),
        .req_slot(req_slot), .req_ready(req_ready), .grant_buf(grant_buf),
        .link_valid(link_valid), .link_slot(link_slot),
        .ret_valid(ret_valid), .ret_buf(ret_buf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_pick(int src, output bit rdy, output int b, output string tag);
        rdy = 0; b = 0; tag = "R6";
        if (m_sv[src]) begin
            b = m_sb[src]; rdy = (m_cnt[b] < QS); tag = rdy ? "R3" : "R7";
        end else begin
            for (int i = NB - 1; i >= 0; i--) if (m_cnt[i] == 0) begin b = i; rdy = 1; tag = "R2"; end
        end
    endtask

    // drive at negedge, then compare against the model
    task automatic drive(bit v, int src, int slot, bit rv, int rb);
        bit rdy; int b; string tag;
        @(negedge clk);
        req_valid = v; req_src = 4'(src); req_slot = 4'(slot);
        ret_valid = rv; ret_buf = 3'(rb);
        #1;
        model_pick(src, rdy, b, tag);
        check(tag, int'(req_ready), int'(rdy));
        if (rdy) begin
            check(tag, int'(grant_buf), b);
            check("R4", int'(link_valid), int'(m_cnt[b] > 0));
            if (m_cnt[b] > 0) check("R4", int'(link_slot), m_last[b]);
        end
    endtask

    task automatic tick();
        bit rdy; int b; string tag;
        model_pick(int'(req_src), rdy, b, tag);
        @(posedge clk);
        if (req_valid && rdy) begin
            m_cnt[b]++; m_last[b] = int'(req_slot);
            m_sv[req_src] = 1; m_sb[req_src] = b;
        end
        if (ret_valid && m_cnt[ret_buf] > 0) m_cnt[ret_buf]--;
        for (int s = 0; s < NS; s++)
            if (m_sv[s] && m_cnt[m_sb[s]] == 0) m_sv[s] = 0;
    endtask

    task automatic step(bit v, int src, int slot, bit rv, int rb);
        drive(v, src, slot, rv, rb);
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errs++; total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, total);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < NB; i++) begin m_cnt[i] = 0; m_last[i] = 0; end
        for (int s = 0; s < NS; s++) begin m_sv[s] = 0; m_sb[s] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: reset state
        drive(1, 3, 5, 0, 0);
        check("R1", int'(req_ready), 1);
        check("R1", int'(grant_buf), 0);
        check("R1", int'(link_valid), 0);
        tick();
        step(1, 5, 6, 0, 0);               // R2: next fresh source -> buf1
        drive(1, 3, 7, 0, 0);              // R3/R4: back to buf0, linked to slot5
        check("R3", int'(grant_buf), 0);
        check("R4", int'(link_slot), 5);
        tick();
        step(0, 0, 0, 1, 0);               // retire buf0 twice -> empty
        step(0, 0, 0, 1, 0);
        drive(1, 3, 2, 0, 0);              // R5: record of src3 dropped, lowest empty is buf0
        check("R5", int'(grant_buf), 0);
        check("R5", int'(link_valid), 0);
        tick();
        // R8: accept and retire on buf0 (count 1) together
        drive(1, 3, 3, 1, 0);
        tick();
        drive(1, 3, 4, 0, 0);
        check("R8", int'(grant_buf), 0);
        check("R8", int'(link_valid), 1);
        check("R8", int'(link_slot), 3);
        tick();
        // R6: fill the remaining buffers with fresh sources
        for (int s = 10; s < 16; s++) step(1, s, s, 0, 0);
        drive(1, 9, 1, 0, 0);
        check("R6", int'(req_ready), 0);
        tick();
        drive(1, 9, 1, 0, 0);
        check("R6", int'(req_ready), 0);
        tick();
        step(0, 0, 0, 1, 1);               // retire src5's single write in buf1
        drive(1, 9, 1, 0, 0);
        check("R6", int'(grant_buf), 1);
        tick();
        // R7: saturate buf0 for src3
        for (int k = 0; k < QS; k++) step(1, 3, k, 0, 0);
        drive(1, 3, 0, 0, 0);
        check("R7", int'(req_ready), 0);
        tick();

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int rb;
            bit rv;
            rb = int'($urandom % NB);
            rv = ($urandom % 10 < 6) && (m_cnt[rb] > 0);
            step(($urandom % 10) < 7, int'($urandom % NS), int'($urandom % QS), rv, rb);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, total);
        $finish;
    end
endmodule